// File: doc/BRIEF.md
# Histogram-Valley Adaptive Threshold Finder

This block derives a per-frame detection threshold from a map of averaged squared distances between a captured image and its reconstruction. The map arrives one value per valid cycle, column after column, with a fixed number of rows per column and a fixed number of columns per frame. For each column the block keeps the largest value seen. It sorts every column maximum into one of a fixed number of equal-width intervals and counts how many maxima fall into each interval. While it counts, it also keeps track of which interval has the highest count.

When the last column has been counted, a scanner walks the histogram upward from the peak interval, one interval per clock. It looks for the first interval whose count is larger than the count of the interval just below it. That interval is taken to be the valley between the background and a new object, and the threshold becomes the lower edge of that interval. If the scan reaches the top interval without finding one, the block reports that the frame holds no object. It then sets the threshold to the top of the covered span, so that every pixel falls below it. Software programs the interval width, and the intervals together span the interval count times that width.

Top module: `valley_threshold_finder`

## Requirements
- R1: Each column's maximum is the largest of its ROWS input values, wherever in the column that value appears.
- R2: A column maximum v goes to interval k when k*bin_width <= v < (k+1)*bin_width; values at or above (NBINS-1)*bin_width go to the last interval (NBINS-1).
- R3: A frame_start pulse clears all interval counts, the peak count and the peak interval, so no earlier frame affects the result.
- R4: The peak interval is the interval whose count first becomes strictly larger than every earlier stored peak count; an interval that only ties the peak does not replace it.
- R5: The scan starts at the peak interval and selects the first higher interval whose count is strictly greater than the count of the interval below it; thr then equals that interval index times bin_width and no_object is 0.
- R6: If no interval above the peak qualifies, including when the peak is the last interval, thr equals NBINS*bin_width and no_object is 1.
- R7: done is a one-cycle pulse per frame, and thr and no_object change only in a cycle where done is high.
- R8: Valid pixels that arrive after the last column of a frame and before the next frame_start are ignored.
- R9: frame_start cancels any pending result; done is low in the cycle after frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that opens a new frame and clears the histogram |
| px_valid | input | 1 | Distance value present on px_dist |
| px_dist | input | DIST_W | Averaged distance, column-major order |
| bin_width | input | DIST_W | Width of each histogram interval |
| done | output | 1 | One-cycle pulse when the threshold for the frame is ready |
| thr | output | DIST_W+BIN_W | Threshold, held until the next done |
| no_object | output | 1 | High when the scan found no valley |

## Verification
The assertions check, on every cycle, that done lasts a single cycle, that thr and no_object move only together with done, that done never follows frame_start directly, that a no-object result carries the top-of-span threshold, and that a valley result stays inside the span. Whether the right interval was chosen can only be shown by the bench's frames. Those frames set up a clear valley, a falling histogram, saturated maxima, tied peak counts, maxima exactly on interval edges, column maxima at different row positions, and stray pixels after a frame's last column.

// File: rtl/vt_pkg.sv
package vt_pkg;
  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_LOAD = 2'd1,
    SC_SCAN = 2'd2
  } scan_st_t;
endpackage

// File: rtl/vt_colmax.sv
module vt_colmax #(
  parameter int ROWS   = 8,
  parameter int COLS   = 16,
  parameter int DIST_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              px_valid,
  input  logic [DIST_W-1:0] px_dist,
  output logic              cm_valid,
  output logic [DIST_W-1:0] cm_value,
  output logic              cm_last
);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;

  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              active_q;
  logic [DIST_W-1:0] run_q;
  logic [DIST_W-1:0] cur;

  always_comb begin
    if (row_q == '0) cur = px_dist;
    else             cur = (px_dist > run_q) ? px_dist : run_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q    <= '0;
      col_q    <= '0;
      active_q <= 1'b0;
      run_q    <= '0;
      cm_valid <= 1'b0;
      cm_value <= '0;
      cm_last  <= 1'b0;
    end else if (frame_start) begin
      row_q    <= '0;
      col_q    <= '0;
      active_q <= 1'b1;
      cm_valid <= 1'b0;
      cm_last  <= 1'b0;
    end else begin
      cm_valid <= 1'b0;
      cm_last  <= 1'b0;
      if (px_valid && active_q) begin
        run_q <= cur;
        if (row_q == ROW_W'(ROWS-1)) begin
          row_q    <= '0;
          cm_valid <= 1'b1;
          cm_value <= cur;
          if (col_q == COL_W'(COLS-1)) begin
            cm_last  <= 1'b1;
            active_q <= 1'b0;
            col_q    <= '0;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end else begin
          row_q <= row_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vt_binmap.sv
module vt_binmap #(
  parameter int DIST_W = 16,
  parameter int NBINS  = 10,
  parameter int BIN_W  = $clog2(NBINS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              in_valid,
  input  logic [DIST_W-1:0] in_value,
  input  logic              in_last,
  input  logic [DIST_W-1:0] bin_width,
  output logic              bin_valid,
  output logic [BIN_W-1:0]  bin_idx,
  output logic              bin_last
);
  localparam int EW = DIST_W + BIN_W;

  logic [NBINS-1:0] ge;
  logic [BIN_W-1:0] idx_c;

  assign ge[0] = 1'b0;
  for (genvar k = 1; k < NBINS; k++) begin : g_edge
    logic [EW-1:0] edge_k;
    assign edge_k = EW'(k) * EW'(bin_width);
    assign ge[k]  = (EW'(in_value) >= edge_k);
  end

  always_comb begin
    idx_c = '0;
    for (int k = 1; k < NBINS; k++) begin
      if (ge[k]) idx_c = BIN_W'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      bin_valid <= 1'b0;
      bin_idx   <= '0;
      bin_last  <= 1'b0;
    end else begin
      bin_valid <= in_valid;
      bin_last  <= in_valid && in_last;
      if (in_valid) bin_idx <= idx_c;
    end
  end
endmodule

// File: rtl/vt_hist.sv
module vt_hist #(
  parameter int NBINS = 10,
  parameter int CNT_W = 5,
  parameter int BIN_W = $clog2(NBINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             inc_valid,
  input  logic [BIN_W-1:0] inc_bin,
  input  logic             inc_last,
  input  logic [BIN_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_cnt,
  output logic [BIN_W-1:0] peak_bin,
  output logic             built
);
  logic [CNT_W-1:0] cnt_q [NBINS];
  logic [CNT_W-1:0] peak_cnt_q;
  logic [CNT_W-1:0] next_cnt;

  assign next_cnt = cnt_q[inc_bin] + 1'b1;
  assign rd_cnt   = cnt_q[rd_addr];

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      for (int i = 0; i < NBINS; i++) cnt_q[i] <= '0;
      peak_cnt_q <= '0;
      peak_bin   <= '0;
      built      <= 1'b0;
    end else begin
      built <= inc_valid && inc_last;
      if (inc_valid) begin
        cnt_q[inc_bin] <= next_cnt;
        if (next_cnt > peak_cnt_q) begin
          peak_cnt_q <= next_cnt;
          peak_bin   <= inc_bin;
        end
      end
    end
  end
endmodule

// File: rtl/vt_scan.sv
module vt_scan
  import vt_pkg::*;
#(
  parameter int DIST_W = 16,
  parameter int NBINS  = 10,
  parameter int CNT_W  = 5,
  parameter int BIN_W  = $clog2(NBINS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_start,
  input  logic                    built,
  input  logic [BIN_W-1:0]        peak_bin,
  input  logic [CNT_W-1:0]        rd_cnt,
  input  logic [DIST_W-1:0]       bin_width,
  output logic [BIN_W-1:0]        rd_addr,
  output logic                    done,
  output logic [DIST_W+BIN_W-1:0] thr,
  output logic                    no_object
);
  localparam int TW = DIST_W + BIN_W;
  localparam logic [BIN_W-1:0] TOP = BIN_W'(NBINS-1);

  scan_st_t         st_q;
  logic [BIN_W-1:0] idx_q;
  logic [CNT_W-1:0] prev_q;
  logic [TW-1:0]    span_top;
  logic [TW-1:0]    edge_idx;

  assign span_top = TW'(NBINS) * TW'(bin_width);
  assign edge_idx = TW'(idx_q) * TW'(bin_width);
  assign rd_addr  = (st_q == SC_LOAD) ? peak_bin : idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= SC_IDLE;
      idx_q     <= '0;
      prev_q    <= '0;
      done      <= 1'b0;
      thr       <= '0;
      no_object <= 1'b0;
    end else if (frame_start) begin
      st_q <= SC_IDLE;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        SC_IDLE: if (built) st_q <= SC_LOAD;
        SC_LOAD: begin
          prev_q <= rd_cnt;
          if (peak_bin == TOP) begin
            thr       <= span_top;
            no_object <= 1'b1;
            done      <= 1'b1;
            st_q      <= SC_IDLE;
          end else begin
            idx_q <= peak_bin + 1'b1;
            st_q  <= SC_SCAN;
          end
        end
        SC_SCAN: begin
          if (rd_cnt > prev_q) begin
            thr       <= edge_idx;
            no_object <= 1'b0;
            done      <= 1'b1;
            st_q      <= SC_IDLE;
          end else if (idx_q == TOP) begin
            thr       <= span_top;
            no_object <= 1'b1;
            done      <= 1'b1;
            st_q      <= SC_IDLE;
          end else begin
            prev_q <= rd_cnt;
            idx_q  <= idx_q + 1'b1;
          end
        end
        default: st_q <= SC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/valley_threshold_finder.sv
module valley_threshold_finder #(
  parameter int ROWS   = 8,
  parameter int COLS   = 16,
  parameter int DIST_W = 16,
  parameter int NBINS  = 10,
  parameter int BIN_W  = $clog2(NBINS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_start,
  input  logic                    px_valid,
  input  logic [DIST_W-1:0]       px_dist,
  input  logic [DIST_W-1:0]       bin_width,
  output logic                    done,
  output logic [DIST_W+BIN_W-1:0] thr,
  output logic                    no_object
);
  localparam int CNT_W = $clog2(COLS + 1);

  logic              cm_valid, cm_last;
  logic [DIST_W-1:0] cm_value;
  logic              bin_valid, bin_last;
  logic [BIN_W-1:0]  bin_idx;
  logic [BIN_W-1:0]  rd_addr, peak_bin;
  logic [CNT_W-1:0]  rd_cnt;
  logic              built;

  vt_colmax #(.ROWS(ROWS), .COLS(COLS), .DIST_W(DIST_W)) u_colmax (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .px_valid(px_valid), .px_dist(px_dist),
    .cm_valid(cm_valid), .cm_value(cm_value), .cm_last(cm_last)
  );

  vt_binmap #(.DIST_W(DIST_W), .NBINS(NBINS), .BIN_W(BIN_W)) u_binmap (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .in_valid(cm_valid), .in_value(cm_value), .in_last(cm_last),
    .bin_width(bin_width),
    .bin_valid(bin_valid), .bin_idx(bin_idx), .bin_last(bin_last)
  );

  vt_hist #(.NBINS(NBINS), .CNT_W(CNT_W), .BIN_W(BIN_W)) u_hist (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .inc_valid(bin_valid), .inc_bin(bin_idx), .inc_last(bin_last),
    .rd_addr(rd_addr), .rd_cnt(rd_cnt), .peak_bin(peak_bin), .built(built)
  );

  vt_scan #(.DIST_W(DIST_W), .NBINS(NBINS), .CNT_W(CNT_W), .BIN_W(BIN_W)) u_scan (
    .clk(clk), .rst(rst), .frame_start(frame_start), .built(built),
    .peak_bin(peak_bin), .rd_cnt(rd_cnt), .bin_width(bin_width),
    .rd_addr(rd_addr), .done(done), .thr(thr), .no_object(no_object)
  );
endmodule

// File: rtl/vt_checker.sv
module vt_checker #(
  parameter int DIST_W = 16,
  parameter int NBINS  = 10,
  parameter int BIN_W  = $clog2(NBINS)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    frame_start,
  input logic [DIST_W-1:0]       bin_width,
  input logic                    done,
  input logic [DIST_W+BIN_W-1:0] thr,
  input logic                    no_object
);
  localparam int TW = DIST_W + BIN_W;
  logic [TW-1:0] top_c;
  assign top_c = TW'(NBINS) * TW'(bin_width);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_THR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(thr) && $stable(no_object))); // R7
  AST_START_CANCEL: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !done); // R9
  AST_FALLBACK_TOP: assert property (@(posedge clk) disable iff (rst)
    (done && no_object) |-> (thr == top_c)); // R6
  AST_VALLEY_IN_SPAN: assert property (@(posedge clk) disable iff (rst)
    (done && !no_object) |-> (thr < top_c)); // R5
endmodule

bind valley_threshold_finder vt_checker #(.DIST_W(DIST_W), .NBINS(NBINS), .BIN_W(BIN_W)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .bin_width(bin_width),
  .done(done), .thr(thr), .no_object(no_object)
);

// File: tb/sim_valley_threshold_finder.sv
module sim_valley_threshold_finder;
  localparam int ROWS = 4, COLS = 12, DIST_W = 16, NBINS = 10;
  localparam int BIN_W = $clog2(NBINS);
  localparam int W = 10;

  logic clk = 1'b0, rst = 1'b1, frame_start = 1'b0, px_valid = 1'b0;
  logic [DIST_W-1:0] px_dist = '0, bin_width = DIST_W'(W);
  logic done, no_object;
  logic [DIST_W+BIN_W-1:0] thr;

  int checks = 0, errors = 0;
  int exp_q[$];
  logic prev_done = 1'b0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  valley_threshold_finder #(.ROWS(ROWS), .COLS(COLS), .DIST_W(DIST_W), .NBINS(NBINS)) u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .px_valid(px_valid),
    .px_dist(px_dist), .bin_width(bin_width),
    .done(done), .thr(thr), .no_object(no_object)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected result packed as thr*2 + no_object, computed from R2, R4, R5, R6
  function automatic int model(input int mx[COLS]);
    int h[NBINS];
    int pk, pc, b, prev, res;
    for (int i = 0; i < NBINS; i++) h[i] = 0;
    pk = 0; pc = 0;
    for (int c = 0; c < COLS; c++) begin
      b = mx[c] / W;
      if (b > NBINS-1) b = NBINS-1;
      h[b]++;
      if (h[b] > pc) begin pc = h[b]; pk = b; end
    end
    res = NBINS*W*2 + 1;
    prev = h[pk];
    for (int i = pk + 1; i < NBINS; i++) begin
      if (h[i] > prev) begin res = i*W*2; break; end
      prev = h[i];
    end
    return res;
  endfunction

  // driver: one frame, column maximum placed at row maxrow
  task automatic run_frame(input int mx[COLS], input int maxrow, input int hand_exp, input bit stray);
    int e;
    e = model(mx);
    if (hand_exp >= 0) chk("R5/R6 model", e, hand_exp);
    exp_q.push_back(e);
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    for (int c = 0; c < COLS; c++) begin
      for (int r = 0; r < ROWS; r++) begin
        px_valid = 1'b1;
        if (r == maxrow) px_dist = DIST_W'(mx[c]);
        else             px_dist = DIST_W'((mx[c] > r + 1) ? mx[c] - r - 1 : 0);
        @(negedge clk);
      end
    end
    px_valid = 1'b0;
    if (stray) begin
      // R8: values after the last column must not be counted
      for (int k = 0; k < 2*ROWS; k++) begin
        px_valid = 1'b1; px_dist = '1; @(negedge clk);
      end
      px_valid = 1'b0;
    end
    while (exp_q.size() != 0 && !finished) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_done && done) chk("R7 done width", 1, 0);
      if (done) begin
        if (exp_q.size() == 0) chk("R7/R8 unexpected done", 1, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk("R5/R6 thr", int'(thr), e / 2);
          chk("R5/R6 no_object", int'(no_object), e % 2);
        end
      end
      prev_done <= done;
    end
  end

  initial begin
    #4_000_000;
    if (!finished) begin
      chk("watchdog", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int fa[COLS] = '{3, 12, 31, 7, 40, 0, 35, 18, 9, 45, 39, 5};
    int fb[COLS] = '{1, 12, 2, 15, 25, 3, 4, 17, 22, 5, 6, 19};
    int fc[COLS] = '{100, 200, 99, 65535, 150, 90, 120, 300, 500, 95, 110, 130};
    int fd[COLS] = '{21, 52, 73, 22, 53, 74, 23, 54, 75, 24, 55, 76};
    int fe[COLS] = '{10, 10, 10, 10, 10, 10, 10, 10, 10, 9, 29, 30};
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R7 reset done", int'(done), 0);
    chk("R7 reset thr", int'(thr), 0);
    chk("R7 reset no_object", int'(no_object), 0);
    // R1 R5: valley at interval 3, max at last row
    run_frame(fa, ROWS-1, 30*2, 1'b0);
    // R6: falling histogram, max at first row; R3 clears earlier frame
    run_frame(fb, 0, NBINS*W*2 + 1, 1'b0);
    // R2 R6: saturated maxima, peak at last interval
    run_frame(fc, 1, NBINS*W*2 + 1, 1'b0);
    // R4: tied counts keep earliest peak, valley at 5
    run_frame(fd, 2, 50*2, 1'b0);
    // R2: maxima exactly on interval edges
    run_frame(fe, ROWS-1, NBINS*W*2 + 1, 1'b1);
    // R8 R3: after stray pixels a fresh frame is unaffected
    run_frame(fa, 0, 30*2, 1'b0);
    // R9: frame_start cancels a pending result mid-frame
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    for (int k = 0; k < ROWS*COLS - 1; k++) begin
      px_valid = 1'b1; px_dist = DIST_W'(k); @(negedge clk);
    end
    px_valid = 1'b0;
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    chk("R9 done after start", int'(done), 0);
    repeat (20) @(negedge clk);
    chk("R9 no result from cancelled frame", int'(done), 0);
    run_frame(fd, 0, 50*2, 1'b0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule